// File: doc/BRIEF.md
# Half-Bridge Switch Control with Fault Latching

This block is the digital control core for three half bridges, each made of one high-side and one low-side power switch. It takes a 16-bit control word that a serial front end has already committed, a strobe that marks each commit, an external PWM line, and per-switch fault flags from the analog sensing. From these it drives six gate-enable outputs and a 16-bit status word that the front end shifts back out.

A switch conducts only when its on bit is set and the global run bit is set. If PWM gating is chosen for that switch, the PWM line must also be high. In addition the supply must be healthy and the switch must not be latched off by a fault. Overcurrent and undervoltage are filtered by cycle-count delays before they take effect. Overtemperature latches a switch off at once. Latched switches and the sticky supply-fail and overload flags are released only by a status-reset request carried by a commit strobe.

Each bridge has its own guard against cross-conduction. The guard never lets both sides of one bridge conduct. When the bridge changes sides, it holds both sides off for a programmable dead time.

Top module: `bridge_drive_ctrl`

## Requirements
- R1: During reset and until the first edge after it, `gate_en` and `status` are all zero. Gate bit i (0..5 = LS1, HS1, LS2, HS2, LS3, HS3) follows control bit 1+i. Every gate output is registered: it changes at the first clock edge after its inputs change.
- R2: When control bit 7+i is set, gate i is also ANDed with `pwm_in`. It turns off at the first edge after `pwm_in` falls and turns back on at the first edge after `pwm_in` rises.
- R3: While control bit 15 is low, all gates go off at the next edge and status bit 14 reads 1. While bit 15 is high, status bit 14 reads 0.
- R4: Suppose `uv_raw` is sampled high on UV_DLY consecutive edges. At the following edge all gates go off and status bit 15 (supply fail) sets. A shorter pulse has no effect. The gates return at the second edge after `uv_raw` falls. Bit 15 stays set until a status reset.
- R5: With control bit 14 set, suppose `oc_raw[i]` is sampled high on OC_DLY consecutive edges. Status bit 13 (overload) sets at the next edge, and gate i latches off one edge after that. With bit 14 clear, overcurrent never trips a switch or sets bit 13.
- R6: `ot_raw[i]` high sets bit 13 at the next edge and latches gate i off one edge later. The latch holds while `ot_raw[i]` stays high, even if a status reset arrives.
- R7: A status reset is `commit` high while control bit 0 is high, for one cycle. At that edge it clears bits 13 and 15 and releases every switch whose fault has cleared. Keeping bit 0 high without a commit releases nothing.
- R8: While control bit 13 is high, status bit 1+i equals `gate_en[i]` in every cycle.
- R9: While control bit 13 is low, status bit 1+i equals `open_load[i]` for a switch whose on bit is clear, and 0 for a switch whose on bit is set. A status reset does not clear it.
- R10: Status bit 0 equals `prewarn` as it was sampled at the previous edge. It is not latched. Status bits 7 to 12 are always 0.
- R11: The two gates of one bridge are never high together. After one side goes off, the other side stays off for exactly DEAD_CYC cycles before turning on. A side that was itself the last one on may turn on again without waiting.
- R12: If both sides of a bridge are requested at once, both gates go off at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Committed control word |
| commit | input | 1 | One-cycle strobe marking a commit |
| pwm_in | input | 1 | External PWM line, high = on |
| oc_raw | input | 6 | Per-switch overcurrent flags |
| ot_raw | input | 6 | Per-switch overtemperature flags |
| prewarn | input | 1 | Temperature prewarning flag |
| open_load | input | 6 | Per-switch open-load sense |
| uv_raw | input | 1 | Raw supply undervoltage flag |
| gate_en | output | 6 | Gate enables LS1, HS1, LS2, HS2, LS3, HS3 |
| status | output | 16 | Status word |

## Verification
The hardest case to reach is a latched switch that gets a status reset while its fault is still active, and then stays off after the fault clears until a second reset arrives. Nothing must re-arm it in between, even though control bit 0 remains stored. The directed sequence raises the overtemperature flag and pulses a commit with bit 0 set while the flag is still high. It then drops the flag and leaves bit 0 high with no commit for several cycles before the final commit. The filter windows are probed one cycle short of and exactly at their lengths. The randomized part holds each random word long enough for any dead-time wait to finish before it compares the steady state.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int NUM_LEGS = 3;
  localparam int NUM_SW   = 2 * NUM_LEGS;
  localparam int WORD_W   = 16;

  // control word field positions
  localparam int CW_RST   = 0;
  localparam int CW_ON0   = 1;
  localparam int CW_PWM0  = CW_ON0 + NUM_SW;
  localparam int CW_OLSEL = 13;
  localparam int CW_OCEN  = 14;
  localparam int CW_RUN   = 15;

  // status word field positions
  localparam int ST_WARN  = 0;
  localparam int ST_SW0   = 1;
  localparam int ST_OVL   = 13;
  localparam int ST_STBY  = 14;
  localparam int ST_SUPF  = 15;
endpackage

// File: rtl/bdc_delay_filter.sv
module bdc_delay_filter #(
  parameter int DLY = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (!raw) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (cnt == CW'(DLY - 1)) begin
      filt <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4 / R5: the filtered flag can only rise while the raw flag was present
  a_r4_filter_needs_raw: assert property (@(posedge clk) disable iff (rst)
    $rose(filt) |-> $past(raw));
endmodule

// File: rtl/bdc_fault_latch.sv
module bdc_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic oc_hit,
  input  logic ot_hit,
  input  logic clr_req,
  output logic tripped,
  output logic trip_evt
);
  assign trip_evt = oc_hit | ot_hit;

  always_ff @(posedge clk) begin
    if (rst)
      tripped <= 1'b0;
    else if (trip_evt)
      tripped <= 1'b1;
    else if (clr_req)
      tripped <= 1'b0;
  end

  // R6: without a reset request a latched switch stays latched
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (tripped && !clr_req) |=> tripped);
  // R6: a reset request during an active overtemperature does not release
  a_r6_no_release_hot: assert property (@(posedge clk) disable iff (rst)
    (tripped && ot_hit) |=> tripped);
endmodule

// File: rtl/bdc_leg.sv
module bdc_leg #(
  parameter int DEAD_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic req_lo,
  input  logic req_hi,
  output logic gate_lo,
  output logic gate_hi,
  output logic nxt_lo,
  output logic nxt_hi
);
  localparam int GAP = DEAD_CYC - 1;
  localparam int CW  = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  logic [CW-1:0] off_cnt;
  logic          last_hi;
  logic          dead_ok;

  assign dead_ok = (off_cnt == CW'(GAP));

  always_comb begin
    nxt_lo = req_lo & ~req_hi & ~gate_hi & (gate_lo | ~last_hi | dead_ok);
    nxt_hi = req_hi & ~req_lo & ~gate_lo & (gate_hi |  last_hi | dead_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_lo <= 1'b0;
      gate_hi <= 1'b0;
      off_cnt <= CW'(GAP);
      last_hi <= 1'b0;
    end else begin
      gate_lo <= nxt_lo;
      gate_hi <= nxt_hi;
      if (gate_lo || gate_hi)
        off_cnt <= '0;
      else if (!dead_ok)
        off_cnt <= off_cnt + 1'b1;
      if (gate_lo)
        last_hi <= 1'b0;
      else if (gate_hi)
        last_hi <= 1'b1;
    end
  end

  // R11: the two sides never conduct together
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(gate_lo && gate_hi));
  // R11: a side turns on only after the other side was off for a cycle
  a_r11_hi_after_lo_off: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> !$past(gate_lo));
  a_r11_lo_after_hi_off: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> !$past(gate_hi));
  // R12: a double request leaves the bridge off
  a_r12_double_req_off: assert property (@(posedge clk) disable iff (rst)
    (req_lo && req_hi) |=> (!gate_lo && !gate_hi));
endmodule

// File: rtl/bridge_drive_ctrl.sv
module bridge_drive_ctrl
  import bdc_pkg::*;
#(
  parameter int UV_DLY   = 1000,
  parameter int OC_DLY   = 1000,
  parameter int DEAD_CYC = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic              commit,
  input  logic              pwm_in,
  input  logic [NUM_SW-1:0] oc_raw,
  input  logic [NUM_SW-1:0] ot_raw,
  input  logic              prewarn,
  input  logic [NUM_SW-1:0] open_load,
  input  logic              uv_raw,
  output logic [NUM_SW-1:0] gate_en,
  output logic [WORD_W-1:0] status
);
  logic              run_en, oc_en, ol_sel, clr_pulse;
  logic              uv_filt;
  logic [NUM_SW-1:0] on_cmd, pwm_sel, oc_filt, tripped, trip_evt, req, gate_nxt;

  logic              supf_q, ovl_q, warn_q, stby_q;
  logic [NUM_SW-1:0] sw_stat_q;

  assign run_en    = ctrl_word[CW_RUN];
  assign oc_en     = ctrl_word[CW_OCEN];
  assign ol_sel    = ctrl_word[CW_OLSEL];
  assign clr_pulse = commit & ctrl_word[CW_RST];
  assign on_cmd    = ctrl_word[CW_ON0 +: NUM_SW];
  assign pwm_sel   = ctrl_word[CW_PWM0 +: NUM_SW];

  bdc_delay_filter #(.DLY(UV_DLY)) u_uv_filt (
    .clk (clk),
    .rst (rst),
    .raw (uv_raw),
    .filt(uv_filt)
  );

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    logic oc_gated;
    assign oc_gated = oc_raw[i] & oc_en;

    bdc_delay_filter #(.DLY(OC_DLY)) u_oc_filt (
      .clk (clk),
      .rst (rst),
      .raw (oc_gated),
      .filt(oc_filt[i])
    );

    bdc_fault_latch u_latch (
      .clk     (clk),
      .rst     (rst),
      .oc_hit  (oc_filt[i]),
      .ot_hit  (ot_raw[i]),
      .clr_req (clr_pulse),
      .tripped (tripped[i]),
      .trip_evt(trip_evt[i])
    );

    assign req[i] = run_en & ~uv_filt & on_cmd[i] & (~pwm_sel[i] | pwm_in) & ~tripped[i];

    // R6: a latched switch is off at the next edge
    a_r6_trip_forces_off: assert property (@(posedge clk) disable iff (rst)
      tripped[i] |=> !gate_en[i]);
  end

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    bdc_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk    (clk),
      .rst    (rst),
      .req_lo (req[2*k]),
      .req_hi (req[2*k+1]),
      .gate_lo(gate_en[2*k]),
      .gate_hi(gate_en[2*k+1]),
      .nxt_lo (gate_nxt[2*k]),
      .nxt_hi (gate_nxt[2*k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      supf_q    <= 1'b0;
      ovl_q     <= 1'b0;
      warn_q    <= 1'b0;
      stby_q    <= 1'b0;
      sw_stat_q <= '0;
    end else begin
      if (uv_filt)
        supf_q <= 1'b1;
      else if (clr_pulse)
        supf_q <= 1'b0;
      if (|trip_evt)
        ovl_q <= 1'b1;
      else if (clr_pulse)
        ovl_q <= 1'b0;
      warn_q    <= prewarn;
      stby_q    <= ~run_en;
      sw_stat_q <= ol_sel ? gate_nxt : (open_load & ~on_cmd);
    end
  end

  always_comb begin
    status                   = '0;
    status[ST_WARN]          = warn_q;
    status[ST_SW0 +: NUM_SW] = sw_stat_q;
    status[ST_OVL]           = ovl_q;
    status[ST_STBY]          = stby_q;
    status[ST_SUPF]          = supf_q;
  end

  // R3: standby turns everything off and reports it
  a_r3_standby: assert property (@(posedge clk) disable iff (rst)
    !ctrl_word[CW_RUN] |=> (gate_en == '0 && status[ST_STBY]));
  // R10: prewarning is passed through with one register of delay
  a_r10_warn_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[ST_WARN] == $past(prewarn)));
  // R4: supply fail is sticky until a reset request
  a_r4_supf_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[ST_SUPF] && !(commit && ctrl_word[CW_RST])) |=> status[ST_SUPF]);
  // R7: overload is sticky until a reset request
  a_r7_ovl_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[ST_OVL] && !(commit && ctrl_word[CW_RST])) |=> status[ST_OVL]);
  // R8: with on-state reporting selected the status mirrors the gates
  a_r8_on_mirror: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[CW_OLSEL] |=> (status[ST_SW0 +: NUM_SW] == gate_en));
endmodule

// File: tb/bridge_drive_ctrl_test.sv
module bridge_drive_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int UV_DLY     = 8;
  localparam int OC_DLY     = 6;
  localparam int DEAD_CYC   = 4;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl_word = '0;
  logic        commit = 1'b0;
  logic        pwm_in = 1'b0;
  logic [5:0]  oc_raw = '0;
  logic [5:0]  ot_raw = '0;
  logic        prewarn = 1'b0;
  logic [5:0]  open_load = '0;
  logic        uv_raw = 1'b0;
  logic [5:0]  gate_en;
  logic [15:0] status;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  localparam logic [15:0] RUN  = 16'h8000;
  localparam logic [15:0] OCEN = 16'h4000;
  localparam logic [15:0] OLS  = 16'h2000;
  localparam logic [15:0] CLR  = 16'h0001;

  bridge_drive_ctrl #(.UV_DLY(UV_DLY), .OC_DLY(OC_DLY), .DEAD_CYC(DEAD_CYC)) uut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .commit(commit), .pwm_in(pwm_in),
    .oc_raw(oc_raw), .ot_raw(ot_raw), .prewarn(prewarn), .open_load(open_load),
    .uv_raw(uv_raw), .gate_en(gate_en), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got cycle %0d exp below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic pulse_commit();
    commit = 1'b1;
    tick(1);
    commit = 1'b0;
  endtask

  function automatic logic [5:0] exp_gates(input logic [15:0] w, input logic p);
    logic [5:0] r, g;
    for (int i = 0; i < 6; i++)
      r[i] = w[15] & w[1+i] & (~w[7+i] | p);
    for (int k = 0; k < 3; k++) begin
      g[2*k]   = r[2*k]   & ~r[2*k+1];
      g[2*k+1] = r[2*k+1] & ~r[2*k];
    end
    return g;
  endfunction

  function automatic logic [15:0] exp_status(input logic [15:0] w, input logic p,
                                             input logic warn, input logic [5:0] ol);
    logic [15:0] s;
    s = '0;
    s[0]    = warn;
    s[6:1]  = w[13] ? exp_gates(w, p) : (ol & ~w[6:1]);
    s[14]   = ~w[15];
    return s;
  endfunction

  initial begin
    // R1: reset state
    tick(3);
    chk("R1 reset gates", {10'h0, gate_en}, 16'h0);
    chk("R1 reset status", status, 16'h0);
    rst = 1'b0;

    // R1: LS1 on with on-state reporting
    ctrl_word = RUN | OLS | 16'h0002;
    tick(1);
    chk("R1 LS1 on", {10'h0, gate_en}, 16'h0001);
    chk("R8 status mirrors LS1", status, 16'h0002);

    // R11: change side on bridge 1, dead time
    ctrl_word = RUN | OLS | 16'h0004;
    tick(1);
    chk("R11 both off after side change", {10'h0, gate_en}, 16'h0000);
    tick(DEAD_CYC - 1);
    chk("R11 still off inside dead time", {10'h0, gate_en}, 16'h0000);
    tick(1);
    chk("R11 HS1 on after dead time", {10'h0, gate_en}, 16'h0002);

    // R12: both requested
    ctrl_word = RUN | OLS | 16'h0006;
    tick(2);
    chk("R12 double request off", {10'h0, gate_en}, 16'h0000);

    // R2: PWM gating of LS2
    ctrl_word = RUN | OLS | 16'h0008 | 16'h0200;
    pwm_in = 1'b1;
    tick(1);
    chk("R2 LS2 on with pwm high", {10'h0, gate_en}, 16'h0004);
    pwm_in = 1'b0;
    tick(1);
    chk("R2 LS2 off with pwm low", {10'h0, gate_en}, 16'h0000);
    chk("R8 status follows pwm off", status, 16'h0000);
    pwm_in = 1'b1;
    tick(1);
    chk("R2 LS2 back on", {10'h0, gate_en}, 16'h0004);

    // R3: standby
    ctrl_word = OLS | 16'h0008;
    tick(1);
    chk("R3 standby gates", {10'h0, gate_en}, 16'h0000);
    chk("R3 standby flag", status, 16'h4000);

    // R10: prewarning pass-through
    prewarn = 1'b1;
    tick(1);
    chk("R10 warn set", status & 16'h0001, 16'h0001);
    prewarn = 1'b0;
    tick(1);
    chk("R10 warn clear", status & 16'h0001, 16'h0000);

    // R4: undervoltage filter
    ctrl_word = RUN | OLS | 16'h0002;
    tick(DEAD_CYC + 2);
    chk("R4 LS1 on before uv", {10'h0, gate_en}, 16'h0001);
    uv_raw = 1'b1;
    tick(UV_DLY - 1);
    uv_raw = 1'b0;
    tick(2);
    chk("R4 short uv ignored", status, 16'h0002);
    uv_raw = 1'b1;
    tick(UV_DLY);
    chk("R4 uv not yet taken", status, 16'h0002);
    tick(1);
    chk("R4 uv gates off", {10'h0, gate_en}, 16'h0000);
    chk("R4 supply fail set", status, 16'h8000);
    uv_raw = 1'b0;
    tick(2);
    chk("R4 gates return", {10'h0, gate_en}, 16'h0001);
    chk("R4 supply fail sticky", status, 16'h8002);
    ctrl_word = RUN | OLS | 16'h0002 | CLR;
    pulse_commit();
    chk("R7 reset clears supply fail", status, 16'h0002);

    // R5: overcurrent with shutdown disabled
    oc_raw = 6'b000001;
    tick(OC_DLY + 4);
    chk("R5 overcurrent ignored when disabled", status, 16'h0002);
    // R5: shutdown enabled
    ctrl_word = RUN | OCEN | OLS | 16'h0002 | CLR;
    tick(OC_DLY + 1);
    chk("R5 overload set", status, 16'h2002);
    tick(1);
    chk("R5 switch latched off", status, 16'h2000);
    oc_raw = 6'b000000;
    tick(3);
    chk("R5 stays off after fault clears", {10'h0, gate_en}, 16'h0000);
    pulse_commit();
    chk("R7 overload cleared", status & 16'h2000, 16'h0000);
    tick(1);
    chk("R7 switch released", {10'h0, gate_en}, 16'h0001);

    // R6: overtemperature
    ot_raw = 6'b000001;
    tick(1);
    chk("R6 overload on overtemp", status & 16'h2000, 16'h2000);
    tick(1);
    chk("R6 switch off on overtemp", {10'h0, gate_en}, 16'h0000);
    pulse_commit();
    tick(1);
    chk("R6 reset while hot ignored", status, 16'h2000);
    ot_raw = 6'b000000;
    tick(4);
    chk("R7 stored reset bit is not a level", status, 16'h2000);
    pulse_commit();
    tick(1);
    chk("R7 release after cool", status, 16'h0002);

    // R9: open-load report
    open_load = 6'b000011;
    ctrl_word = RUN | 16'h0002;
    tick(1);
    chk("R9 open load for off switch only", status, 16'h0004);
    ctrl_word = RUN | 16'h0002 | CLR;
    pulse_commit();
    tick(1);
    chk("R9 reset keeps open load", status, 16'h0004);
    commit = 1'b0;

    // Random steady-state patterns: R1 R2 R3 R8 R9 R10 R11 R12
    begin
      int seed;
      logic [15:0] w;
      seed = 17;
      void'($urandom(seed));
      for (int n = 0; n < 300; n++) begin
        w         = 16'($urandom()) & 16'hFFFE;
        pwm_in    = 1'($urandom());
        prewarn   = 1'($urandom());
        open_load = 6'($urandom());
        ctrl_word = w;
        tick(DEAD_CYC + 2);
        chk("R1 R2 R12 random gates", {10'h0, gate_en}, {10'h0, exp_gates(w, pwm_in)});
        chk("R8 R9 R10 random status", status, exp_status(w, pwm_in, prewarn, open_load));
      end
    end

    finish_run();
  end
endmodule